// File: doc/BRIEF.md
# I2C Master Byte Shifter

This block moves one data frame across an I2C bus while acting as bus master. A start strobe latches the direction, the frame length, the acknowledge option and the outgoing byte. The block then walks SCL through one low and one high phase per bit. If the acknowledge option is set, it adds one more clock for the acknowledge. Both bus lines are open drain: each output tells the pad to pull its line low, and a low output releases the line. The sampled SDA level comes back on `sdaIn`.

Phase lengths come from a separate timing block. Each one-cycle `phaseTick` ends the current SCL phase, and ticks that arrive while no frame runs are ignored. Start and stop conditions, arbitration and the register interface live elsewhere. The register logic asserts `addrFrame` for the first frame after a start condition, because the frame-length field is cleared at that point. The address frame therefore always carries 8 bits.

Top module: `i2cByteShifter`

## Requirements
- R1: After reset, SCL and SDA are both released (`sclDriveLow`=0, `sdaDriveLow`=0), `done` is 0, `rxByte` is 0 and `ackBit` is 1.
- R2: The frame length is set by `bitCountSel`. Values 1 to 7 give that many data bits and 0 gives 8 bits. Each data bit uses one SCL pulse and two phase ticks.
- R3: With `addrFrame`=1 at the start strobe, the frame has 8 data bits whatever `bitCountSel` holds.
- R4: In transmit mode (`isRx`=0), data leaves MSB first, beginning at `txByte[7]`. A 0 bit pulls SDA low and a 1 bit releases it. SDA only changes while SCL is held low.
- R5: SDA is sampled at each SCL rising edge, in both directions. `rxByte` holds the sampled bits right-justified, the first bit most significant, with the unused upper bits 0.
- R6: With `ackEnable`=1, one extra SCL pulse follows the data bits. In transmit mode SDA is released for that whole clock. The SDA level sampled at its rising edge is stored in `ackBit`, where 0 means acknowledged.
- R7: In receive mode with `ackEnable`=1, the block pulls SDA low for the whole acknowledge clock.
- R8: With `ackEnable`=0, no acknowledge pulse is generated and `ackBit` reads 1 after the frame.
- R9: `done` is high for exactly one cycle, the cycle after the tick that ends the last SCL high phase. From that tick on, SCL stays low and SDA stays released until the next start strobe.
- R10: While a frame runs, `startFrame`, `isRx`, `bitCountSel`, `ackEnable` and `txByte` have no effect on it. `phaseTick` has no effect while no frame runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startFrame | input | 1 | One-cycle strobe that begins a frame when idle |
| isRx | input | 1 | 1 = receive, 0 = transmit |
| bitCountSel | input | 3 | Frame length select, 0 means 8 |
| addrFrame | input | 1 | Forces an 8-bit frame (first frame after a start condition) |
| ackEnable | input | 1 | Adds the acknowledge clock |
| txByte | input | 8 | Byte to send, MSB first |
| sdaIn | input | 1 | Sampled SDA line level |
| phaseTick | input | 1 | Ends the current SCL phase |
| sclDriveLow | output | 1 | Pull SCL low |
| sdaDriveLow | output | 1 | Pull SDA low |
| rxByte | output | 8 | Bits sampled during the frame |
| ackBit | output | 1 | SDA level sampled on the acknowledge clock |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
Every result is due a fixed number of register stages after a tick. SCL and SDA change on the clock edge that takes the tick. `rxByte`, `ackBit` and `done` settle on the edge that takes the final tick of the frame. The bench drives each tick on a falling clock edge and reads the outputs on the next falling edge, once that single register stage has acted. It also counts the ticks until `done` appears, so a frame of n bits with acknowledge must finish after exactly 2n+2 ticks, and without acknowledge after exactly 2n ticks.

// File: rtl/i2cShiftPkg.sv
package i2cShiftPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_ACK_LOW,
    ST_ACK_HIGH
  } busPhase_e;

  // strobes and levels passed from control to datapath
  typedef struct packed {
    logic load;
    logic sampleBit;
    logic shiftBit;
    logic sampleAck;
    logic dataPhase;
    logic ackPhase;
    logic rxMode;
  } shiftCtrl_t;

endpackage

// File: rtl/i2cShiftCtrl.sv
module i2cShiftCtrl
  import i2cShiftPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startFrame,
  input  logic             isRx,
  input  logic [CNT_W-1:0] bitCountSel,
  input  logic             addrFrame,
  input  logic             ackEnable,
  input  logic             phaseTick,
  output shiftCtrl_t       ctrl,
  output logic             sclDriveLow,
  output logic             done
);

  localparam int LEFT_W = $clog2(DATA_W + 1);

  busPhase_e         state;
  logic [LEFT_W-1:0] bitsLeft;
  logic [LEFT_W-1:0] reqBits;
  logic              rxModeQ;
  logic              ackOn;
  logic              sclHeld;
  logic              lastBit;

  // zero selects a full-width frame; address frames are always full width
  always_comb begin
    if (addrFrame || (bitCountSel == '0)) reqBits = LEFT_W'(DATA_W);
    else                                  reqBits = LEFT_W'(bitCountSel);
  end

  assign lastBit = (bitsLeft == LEFT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitsLeft <= '0;
      rxModeQ  <= 1'b0;
      ackOn    <= 1'b0;
      sclHeld  <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (startFrame) begin
            state    <= ST_LOW;
            bitsLeft <= reqBits;
            rxModeQ  <= isRx;
            ackOn    <= ackEnable;
          end
        end
        ST_LOW: begin
          if (phaseTick) state <= ST_HIGH;
        end
        ST_HIGH: begin
          if (phaseTick) begin
            if (lastBit) begin
              if (ackOn) begin
                state <= ST_ACK_LOW;
              end else begin
                state   <= ST_IDLE;
                done    <= 1'b1;
                sclHeld <= 1'b1;
              end
            end else begin
              bitsLeft <= bitsLeft - LEFT_W'(1);
              state    <= ST_LOW;
            end
          end
        end
        ST_ACK_LOW: begin
          if (phaseTick) state <= ST_ACK_HIGH;
        end
        ST_ACK_HIGH: begin
          if (phaseTick) begin
            state   <= ST_IDLE;
            done    <= 1'b1;
            sclHeld <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state)
      ST_LOW, ST_ACK_LOW:   sclDriveLow = 1'b1;
      ST_HIGH, ST_ACK_HIGH: sclDriveLow = 1'b0;
      default:              sclDriveLow = sclHeld;
    endcase
  end

  always_comb begin
    ctrl.load      = (state == ST_IDLE) && startFrame;
    ctrl.sampleBit = (state == ST_LOW) && phaseTick;
    ctrl.shiftBit  = (state == ST_HIGH) && phaseTick;
    ctrl.sampleAck = (state == ST_ACK_LOW) && phaseTick;
    ctrl.dataPhase = (state == ST_LOW) || (state == ST_HIGH);
    ctrl.ackPhase  = (state == ST_ACK_LOW) || (state == ST_ACK_HIGH);
    ctrl.rxMode    = rxModeQ;
  end

endmodule

// File: rtl/i2cShiftData.sv
module i2cShiftData
  import i2cShiftPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  shiftCtrl_t        ctrl,
  input  logic [DATA_W-1:0] txByte,
  input  logic              sdaIn,
  output logic              sdaDriveLow,
  output logic [DATA_W-1:0] rxByte,
  output logic              ackBit
);

  logic [DATA_W-1:0] txShift;
  logic [DATA_W-1:0] rxShift;
  logic              ackQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      ackQ    <= 1'b1;
    end else begin
      if (ctrl.load) begin
        txShift <= txByte;
        rxShift <= '0;
        ackQ    <= 1'b1;
      end else begin
        if (ctrl.shiftBit)  txShift <= {txShift[DATA_W-2:0], 1'b0};
        if (ctrl.sampleBit) rxShift <= {rxShift[DATA_W-2:0], sdaIn};
        if (ctrl.sampleAck) ackQ    <= sdaIn;
      end
    end
  end

  // transmit pulls low for a zero bit; receive pulls low on the ack clock
  assign sdaDriveLow = (ctrl.dataPhase && !ctrl.rxMode && !txShift[DATA_W-1]) ||
                       (ctrl.ackPhase && ctrl.rxMode);
  assign rxByte = rxShift;
  assign ackBit = ackQ;

endmodule

// File: rtl/i2cByteShifter.sv
module i2cByteShifter
  import i2cShiftPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startFrame,
  input  logic              isRx,
  input  logic [CNT_W-1:0]  bitCountSel,
  input  logic              addrFrame,
  input  logic              ackEnable,
  input  logic [DATA_W-1:0] txByte,
  input  logic              sdaIn,
  input  logic              phaseTick,
  output logic              sclDriveLow,
  output logic              sdaDriveLow,
  output logic [DATA_W-1:0] rxByte,
  output logic              ackBit,
  output logic              done
);

  shiftCtrl_t ctrlBus;

  i2cShiftCtrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startFrame(startFrame), .isRx(isRx),
    .bitCountSel(bitCountSel), .addrFrame(addrFrame), .ackEnable(ackEnable),
    .phaseTick(phaseTick), .ctrl(ctrlBus), .sclDriveLow(sclDriveLow), .done(done)
  );

  i2cShiftData #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rstN(rstN), .ctrl(ctrlBus), .txByte(txByte), .sdaIn(sdaIn),
    .sdaDriveLow(sdaDriveLow), .rxByte(rxByte), .ackBit(ackBit)
  );

endmodule

// File: rtl/i2cShiftChecker.sv
module i2cShiftChecker
  import i2cShiftPkg::*;
(
  input logic       clk,
  input logic       rstN,
  input shiftCtrl_t ctrlBus,
  input logic       phaseTick,
  input logic       sclDriveLow,
  input logic       sdaDriveLow,
  input logic       done
);

  a_r4_sda_stable_scl_high: assert property (@(posedge clk) disable iff (!rstN)
    (!sclDriveLow && !$past(sclDriveLow)) |-> $stable(sdaDriveLow));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r9_scl_held_after_done: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (sclDriveLow && !sdaDriveLow));

  a_r5_rx_data_released: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlBus.dataPhase && ctrlBus.rxMode) |-> !sdaDriveLow);

  a_r6_tx_ack_released: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlBus.ackPhase && !ctrlBus.rxMode) |-> !sdaDriveLow);

  a_r7_rx_ack_driven: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlBus.ackPhase && ctrlBus.rxMode) |-> sdaDriveLow);

  a_r10_idle_tick_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlBus.dataPhase && !ctrlBus.ackPhase && phaseTick) |=> !done);

endmodule

bind i2cByteShifter i2cShiftChecker u_chk (
  .clk(clk), .rstN(rstN), .ctrlBus(ctrlBus), .phaseTick(phaseTick),
  .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow), .done(done)
);

// File: tb/sim_i2cByteShifter.sv
module sim_i2cByteShifter;

  typedef struct packed {
    logic       rx;
    logic [2:0] cnt;
    logic       addr;
    logic       ack;
    logic [7:0] tx;
    logic [7:0] slv;
    logic       slvAck;
    logic [7:0] expRx;
    logic       expAck;
    logic [4:0] expTicks;
  } vec_t;

  localparam vec_t VECS [0:7] = '{
    '{1'b0, 3'd0, 1'b0, 1'b1, 8'hA5, 8'h00, 1'b0, 8'hA5, 1'b0, 5'd18},
    '{1'b0, 3'd3, 1'b0, 1'b1, 8'hE0, 8'h00, 1'b1, 8'h07, 1'b1, 5'd8},
    '{1'b1, 3'd0, 1'b0, 1'b1, 8'h00, 8'h3C, 1'b0, 8'h3C, 1'b0, 5'd18},
    '{1'b1, 3'd5, 1'b0, 1'b0, 8'h00, 8'h15, 1'b0, 8'h15, 1'b1, 5'd10},
    '{1'b0, 3'd5, 1'b1, 1'b1, 8'h96, 8'h00, 1'b0, 8'h96, 1'b0, 5'd18},
    '{1'b0, 3'd1, 1'b0, 1'b0, 8'h80, 8'h00, 1'b0, 8'h01, 1'b1, 5'd2},
    '{1'b1, 3'd7, 1'b0, 1'b1, 8'h00, 8'h55, 1'b0, 8'h55, 1'b0, 5'd16},
    '{1'b0, 3'd2, 1'b0, 1'b1, 8'h40, 8'h00, 1'b0, 8'h01, 1'b0, 5'd6}
  };

  logic       clk = 1'b0;
  logic       rstN;
  logic       startFrame, isRx, addrFrame, ackEnable, phaseTick, slaveLow;
  logic [2:0] bitCountSel;
  logic [7:0] txByte;
  logic       sdaIn, sclDriveLow, sdaDriveLow, ackBit, done;
  logic [7:0] rxByte;

  int numChecks = 0;
  int numFails  = 0;
  int cycles    = 0;

  always #5 clk = ~clk;

  // open-drain bus: low if either side pulls
  assign sdaIn = !(sdaDriveLow || slaveLow);

  i2cByteShifter u0 (
    .clk(clk), .rstN(rstN), .startFrame(startFrame), .isRx(isRx),
    .bitCountSel(bitCountSel), .addrFrame(addrFrame), .ackEnable(ackEnable),
    .txByte(txByte), .sdaIn(sdaIn), .phaseTick(phaseTick),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow), .rxByte(rxByte),
    .ackBit(ackBit), .done(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    numChecks++;
    if (act != exp) begin
      numFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", numChecks, numFails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      numChecks++;
      numFails++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      finishRun();
    end
  end

  // runs one frame; disturb changes the command inputs mid-frame (R10)
  task automatic runFrame(input vec_t v, input bit disturb);
    int n;
    int ticks;
    int pulses;
    bit gotDone;
    bit prevScl;
    n = (v.addr || v.cnt == 3'd0) ? 8 : int'(v.cnt);
    @(negedge clk);
    isRx = v.rx; bitCountSel = v.cnt; addrFrame = v.addr;
    ackEnable = v.ack; txByte = v.tx; startFrame = 1'b1;
    @(negedge clk);
    startFrame = 1'b0;
    ticks = 0; pulses = 0; gotDone = 1'b0; prevScl = sclDriveLow;
    while (!gotDone && ticks < 40) begin
      int k;
      k = ticks / 2;
      if (ticks % 2 == 0) begin
        if (k < n) begin
          slaveLow = v.rx ? !v.slv[n-1-k] : 1'b0;
          if (!v.rx) chk("R4 tx bit level", int'(sdaDriveLow), int'(!v.tx[7-k]));
          else       chk("R5 rx data released", int'(sdaDriveLow), 0);
        end else begin
          slaveLow = v.rx ? 1'b0 : !v.slvAck;
          chk(v.rx ? "R7 rx ack drive" : "R6 tx ack release", int'(sdaDriveLow), int'(v.rx));
        end
      end
      if (disturb && ticks == 1) begin
        startFrame = 1'b1; isRx = !v.rx; bitCountSel = 3'd0;
        ackEnable = !v.ack; txByte = ~v.tx;
      end
      phaseTick = 1'b1;
      @(negedge clk);
      phaseTick = 1'b0;
      startFrame = 1'b0;
      ticks++;
      if (prevScl && !sclDriveLow) pulses++;
      prevScl = sclDriveLow;
      if (done) gotDone = 1'b1;
    end
    slaveLow = 1'b0;
    chk("R2 R3 R9 tick count", ticks, int'(v.expTicks));
    chk("R2 R6 R8 scl pulses", pulses, n + int'(v.ack));
    chk("R5 rxByte", int'(rxByte), int'(v.expRx));
    chk("R6 R8 ackBit", int'(ackBit), int'(v.expAck));
    chk("R9 scl held low", int'(sclDriveLow), 1);
    chk("R9 sda released", int'(sdaDriveLow), 0);
    @(negedge clk);
    chk("R9 done one cycle", int'(done), 0);
  endtask

  initial begin
    rstN = 1'b0; startFrame = 1'b0; isRx = 1'b0; addrFrame = 1'b0;
    ackEnable = 1'b0; phaseTick = 1'b0; slaveLow = 1'b0;
    bitCountSel = 3'd0; txByte = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 scl released", int'(sclDriveLow), 0);
    chk("R1 sda released", int'(sdaDriveLow), 0);
    chk("R1 done low", int'(done), 0);
    chk("R1 rxByte", int'(rxByte), 0);
    chk("R1 ackBit", int'(ackBit), 1);

    for (int i = 0; i < 8; i++) runFrame(VECS[i], 1'b0);

    // R10: command inputs changed mid-frame have no effect
    runFrame(VECS[7], 1'b1);

    // R10: ticks while idle are ignored, R9 SCL stays held
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      phaseTick = 1'b1;
      @(negedge clk);
      phaseTick = 1'b0;
      chk("R10 idle tick no done", int'(done), 0);
      chk("R10 R9 idle scl held", int'(sclDriveLow), 1);
      chk("R10 idle rxByte kept", int'(rxByte), 8'h01);
    end

    finishRun();
  end

endmodule